// File: doc/BRIEF.md
# Indexed Mailbox Doorbell Controller

This block is the host-facing register block of a mailbox between a host processor and a security coprocessor. The host sees a 32-word register window. Two index/data pairs in that window reach a 128-entry indirect register file and a separate 64-entry sub-bank. Four scratch words carry a command, an address, a data operand and a return code. A third index/data pair reaches a stub power-management register space. It returns fixed values at a handful of addresses, zero everywhere else, and it discards writes.

The host rings the doorbell by writing 1 to indirect entry 0x31. A sequencer takes a snapshot of the request context and the scratch registers. Indirect entries 0x32 and 0x33 form the request context (high word, low word). Entries 0x35 and 0x36 form the reply context. The request context's upper 16 bits are a flags field. When the flags are zero, the scratch command runs in hardware. Read and write commands go to the power-management space. Unknown commands return an error code. When the flags are nonzero, the request is a packet request: the sequencer raises a one-cycle interrupt that carries a source ID and the two 48-bit context addresses. Every accepted request ends with the same status handshake on entries 0x4A and 0x4B.

The sequencer has four states. IDLE waits for an accepted doorbell (IDLE→DECODE). DECODE goes to PM_ACCESS for a register command (DECODE→PM_ACCESS). It goes straight to COMPLETE for a packet request or an unknown command (DECODE→COMPLETE). PM_ACCESS performs the register access (PM_ACCESS→COMPLETE). COMPLETE posts the results, the status and the interrupt, and returns (COMPLETE→IDLE).

Top module: `mbx_doorbell_ctrl`

## Requirements
- R1: After reset, every window register reads 0, every indirect entry reads 0 and `irq_pulse` is low.
- R2: Word 0 holds the main index and reads back. Word 1 reads and writes the main-file entry that the index selects.
- R3: Word 2 holds the sub-bank index and word 3 reaches the 64-entry sub-bank. The sub-bank is storage separate from the main file, so the same index in each holds an independent value.
- R4: Words 4 to 7 are scratch 0 to scratch 3 and are directly readable and writable. Scratch 0 is the command, scratch 1 the address, scratch 2 the data operand and scratch 3 the return code.
- R5: Word 8 is the power-management index and word 9 its data. The register spaces read as follows:
    - 0xC2100004 reads 3.
    - 0xC0500090, 0xC0500098, 0xC05000E0 and 0xC05000E8 read 1.
    - Every other address reads 0.
    - Writes have no effect.
- R6: A doorbell with zero flags and command 0xA404 loads scratch 2 with the power-management value at the scratch 1 address and clears scratch 3.
- R7: Command 0xA505 clears scratch 3, leaves scratch 2 unchanged and changes no power-management value.
- R8: Any other command with zero flags writes 0xFFFFFFFF into scratch 3, leaves scratch 2 unchanged, and still performs the status handshake.
- R9: Every accepted request clears entry 0x4A and sets bit 0 of entry 0x4B, keeping the other bits of 0x4B.
- R10: The flags field is bits 31:16 of entry 0x32. A doorbell with nonzero flags leaves the scratch registers unchanged. It pulses `irq_pulse` with `irq_src` equal to `SRC_ID`. The two address outputs carry the lower 48 bits of the request context {0x32,0x33} and of the reply context {0x35,0x36}.
- R11: A write to entry 0x37 clears entry 0x4A and is not stored. Entry 0x31 is not stored either. A write to any other entry stores the value.
- R12: Two kinds of doorbell are ignored and change no status. The first is a doorbell write whose value is not 1. The second is a doorbell write while a request is executing.
- R13: `irq_pulse` is high for exactly one cycle per packet request and never for a scratch command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W (5) | Word offset in the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt for a packet request |
| irq_src | output | SRC_ID_W (8) | Interrupt source ID |
| irq_query_addr | output | 48 | Request context address, valid with the interrupt |
| irq_reply_addr | output | 48 | Reply context address, valid with the interrupt |

## Verification
On every cycle, the assertions check four properties:
- The interrupt lasts a single cycle and follows a COMPLETE state.
- The interrupt carries the fixed source ID.
- Every COMPLETE state leaves entry 0x4A cleared and bit 0 of entry 0x4B set.
- PM_ACCESS is entered only from DECODE.

Only the bench scenarios can show the data results. These are the scratch values each command posts, the stub read values, the independence of the two indirect banks, and the ignored doorbells, which leave the status entries and the interrupt count unchanged.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_PM_ACCESS,
        ST_COMPLETE
    } mbx_state_t;

    // window word offsets
    localparam int OFF_IDX    = 0;
    localparam int OFF_DAT    = 1;
    localparam int OFF_SIDX   = 2;
    localparam int OFF_SDAT   = 3;
    localparam int OFF_SCR0   = 4;
    localparam int OFF_SCR3   = 7;
    localparam int OFF_PMIDX  = 8;
    localparam int OFF_PMDAT  = 9;

    // indirect entries
    localparam int IX_DOORBELL = 'h31;
    localparam int IX_REQ_HI   = 'h32;
    localparam int IX_REQ_LO   = 'h33;
    localparam int IX_RSP_HI   = 'h35;
    localparam int IX_RSP_LO   = 'h36;
    localparam int IX_ACK      = 'h37;
    localparam int IX_REQ_STAT = 'h4A;
    localparam int IX_RSP_STAT = 'h4B;

    localparam logic [31:0] CMD_PM_RD = 32'h0000_A404;
    localparam logic [31:0] CMD_PM_WR = 32'h0000_A505;
    localparam logic [31:0] RC_OK     = 32'h0000_0000;
    localparam logic [31:0] RC_ERR    = 32'hFFFF_FFFF;

endpackage

// File: rtl/mbx_pm_stub.sv
module mbx_pm_stub (
    input  logic [31:0] host_addr,
    output logic [31:0] host_data,
    input  logic [31:0] seq_addr,
    output logic [31:0] seq_data
);
    function automatic logic [31:0] pm_value(input logic [31:0] a);
        case (a)
            32'hC210_0004: pm_value = 32'd3;
            32'hC050_0090,
            32'hC050_0098,
            32'hC050_00E0,
            32'hC050_00E8: pm_value = 32'd1;
            default:       pm_value = 32'd0;
        endcase
    endfunction

    assign host_data = pm_value(host_addr);
    assign seq_data  = pm_value(seq_addr);
endmodule

// File: rtl/mbx_ctx.sv
module mbx_ctx (
    input  logic [31:0] req_hi,
    input  logic [31:0] req_lo,
    input  logic [31:0] rsp_hi,
    input  logic [31:0] rsp_lo,
    output logic [15:0] flags,
    output logic [47:0] query_addr,
    output logic [47:0] reply_addr
);
    logic [63:0] req_ctx;
    logic [63:0] rsp_ctx;
    logic [15:0] unused_rsp_top;

    assign req_ctx        = {req_hi, req_lo};
    assign rsp_ctx        = {rsp_hi, rsp_lo};
    assign flags          = req_ctx[63:48];
    assign query_addr     = req_ctx[47:0];
    assign reply_addr     = rsp_ctx[47:0];
    assign unused_rsp_top = rsp_ctx[63:48];
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
#(
    parameter int SRC_ID_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               db_hit,
    input  logic [15:0]        flags_in,
    input  logic [31:0]        cmd_in,
    input  logic [31:0]        addr_in,
    input  logic [47:0]        query_in,
    input  logic [47:0]        reply_in,
    input  logic [31:0]        pm_rdata,
    output logic [31:0]        pm_addr,
    output mbx_state_t         state,
    output logic               done,
    output logic               scr2_we,
    output logic [31:0]        scr2_val,
    output logic               scr3_we,
    output logic [31:0]        scr3_val,
    output logic               irq,
    output logic [47:0]        irq_query,
    output logic [47:0]        irq_reply
);
    mbx_state_t state_q, state_d;
    logic [15:0] flags_q;
    logic [31:0] cmd_q, addr_q, rd_q, rc_q;
    logic [47:0] query_q, reply_q;
    logic        ld_rd_q;
    logic        irq_q;

    logic accept;
    assign accept = db_hit && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        done     = 1'b0;
        scr2_we  = 1'b0;
        scr3_we  = 1'b0;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_DECODE;
            ST_DECODE: begin
                if (flags_q == '0 && (cmd_q == CMD_PM_RD || cmd_q == CMD_PM_WR))
                    state_d = ST_PM_ACCESS;
                else
                    state_d = ST_COMPLETE;
            end
            ST_PM_ACCESS: state_d = ST_COMPLETE;
            ST_COMPLETE: begin
                done    = 1'b1;
                scr2_we = ld_rd_q;
                scr3_we = (flags_q == '0);
                state_d = ST_IDLE;
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0; cmd_q <= '0; addr_q <= '0;
            query_q <= '0; reply_q <= '0;
            rd_q <= '0; rc_q <= '0; ld_rd_q <= 1'b0; irq_q <= 1'b0;
        end else begin
            irq_q <= done && (flags_q != '0);
            if (accept) begin
                flags_q <= flags_in; cmd_q <= cmd_in; addr_q <= addr_in;
                query_q <= query_in; reply_q <= reply_in;
                ld_rd_q <= 1'b0;
                rc_q    <= RC_ERR;
            end
            if (state_q == ST_PM_ACCESS) begin
                rc_q <= RC_OK;
                if (cmd_q == CMD_PM_RD) begin
                    rd_q    <= pm_rdata;
                    ld_rd_q <= 1'b1;
                end
            end
        end
    end

    assign state     = state_q;
    assign pm_addr   = addr_q;
    assign scr2_val  = rd_q;
    assign scr3_val  = rc_q;
    assign irq       = irq_q;
    assign irq_query = query_q;
    assign irq_reply = reply_q;
endmodule

// File: rtl/mbx_doorbell_ctrl.sv
module mbx_doorbell_ctrl
    import mbx_pkg::*;
#(
    parameter int                ADDR_W      = 5,
    parameter int                IX_ENTRIES  = 128,
    parameter int                SUB_ENTRIES = 64,
    parameter int                SRC_ID_W    = 8,
    parameter logic [SRC_ID_W-1:0] SRC_ID    = 8'h98
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [31:0]         host_wdata,
    output logic [31:0]         host_rdata,
    output logic                irq_pulse,
    output logic [SRC_ID_W-1:0] irq_src,
    output logic [47:0]         irq_query_addr,
    output logic [47:0]         irq_reply_addr
);
    localparam int IXW  = $clog2(IX_ENTRIES);
    localparam int SIXW = $clog2(SUB_ENTRIES);

    logic [31:0]     ind_file [IX_ENTRIES];
    logic [31:0]     sub_file [SUB_ENTRIES];
    logic [31:0]     scr      [4];
    logic [IXW-1:0]  ix_q;
    logic [SIXW-1:0] six_q;
    logic [31:0]     pmix_q;

    logic [15:0] ctx_flags;
    logic [47:0] ctx_query, ctx_reply;
    logic [31:0] pm_host_data, pm_seq_data, pm_seq_addr;
    mbx_state_t  seq_state;
    logic        seq_done, scr2_we, scr3_we, db_hit;
    logic [31:0] scr2_val, scr3_val;

    assign db_hit = host_wr && (int'(host_addr) == OFF_DAT)
                 && (int'(ix_q) == IX_DOORBELL) && (host_wdata == 32'd1);

    mbx_ctx u_ctx (
        .req_hi(ind_file[IX_REQ_HI]), .req_lo(ind_file[IX_REQ_LO]),
        .rsp_hi(ind_file[IX_RSP_HI]), .rsp_lo(ind_file[IX_RSP_LO]),
        .flags(ctx_flags), .query_addr(ctx_query), .reply_addr(ctx_reply)
    );

    mbx_pm_stub u_pm (
        .host_addr(pmix_q), .host_data(pm_host_data),
        .seq_addr(pm_seq_addr), .seq_data(pm_seq_data)
    );

    mbx_seq #(.SRC_ID_W(SRC_ID_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .db_hit(db_hit),
        .flags_in(ctx_flags), .cmd_in(scr[0]), .addr_in(scr[1]),
        .query_in(ctx_query), .reply_in(ctx_reply),
        .pm_rdata(pm_seq_data), .pm_addr(pm_seq_addr),
        .state(seq_state), .done(seq_done),
        .scr2_we(scr2_we), .scr2_val(scr2_val),
        .scr3_we(scr3_we), .scr3_val(scr3_val),
        .irq(irq_pulse), .irq_query(irq_query_addr), .irq_reply(irq_reply_addr)
    );

    assign irq_src = SRC_ID;

    // register writes; sequencer results take priority over the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < IX_ENTRIES; i++)  ind_file[i] <= '0;
            for (int i = 0; i < SUB_ENTRIES; i++) sub_file[i] <= '0;
            for (int i = 0; i < 4; i++)           scr[i]      <= '0;
            ix_q <= '0; six_q <= '0; pmix_q <= '0;
        end else begin
            if (host_wr) begin
                case (int'(host_addr))
                    OFF_IDX:   ix_q  <= host_wdata[IXW-1:0];
                    OFF_SIDX:  six_q <= host_wdata[SIXW-1:0];
                    OFF_SDAT:  sub_file[six_q] <= host_wdata;
                    OFF_PMIDX: pmix_q <= host_wdata;
                    OFF_DAT: begin
                        if (int'(ix_q) == IX_ACK)
                            ind_file[IX_REQ_STAT] <= '0;
                        else if (int'(ix_q) != IX_DOORBELL)
                            ind_file[ix_q] <= host_wdata;
                    end
                    default: begin
                        if (int'(host_addr) >= OFF_SCR0 && int'(host_addr) <= OFF_SCR3)
                            scr[host_addr[1:0]] <= host_wdata;
                    end
                endcase
            end
            if (seq_done) begin
                ind_file[IX_REQ_STAT]    <= '0;
                ind_file[IX_RSP_STAT][0] <= 1'b1;
                if (scr2_we) scr[2] <= scr2_val;
                if (scr3_we) scr[3] <= scr3_val;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        case (int'(host_addr))
            OFF_IDX:   host_rdata = 32'(ix_q);
            OFF_DAT:   host_rdata = ind_file[ix_q];
            OFF_SIDX:  host_rdata = 32'(six_q);
            OFF_SDAT:  host_rdata = sub_file[six_q];
            OFF_PMIDX: host_rdata = pmix_q;
            OFF_PMDAT: host_rdata = pm_host_data;
            default: begin
                if (int'(host_addr) >= OFF_SCR0 && int'(host_addr) <= OFF_SCR3)
                    host_rdata = scr[host_addr[1:0]];
            end
        endcase
    end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int                  SRC_ID_W = 8,
    parameter logic [SRC_ID_W-1:0] SRC_ID   = 8'h98
) (
    input logic                clk,
    input logic                rst_n,
    input mbx_state_t          state,
    input logic                done,
    input logic                irq,
    input logic [SRC_ID_W-1:0] irq_src,
    input logic [31:0]         req_stat,
    input logic [31:0]         rsp_stat
);
    // R13
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R13
    irq_after_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(done));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_src == SRC_ID);

    // R9
    status_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_stat == 32'd0) && rsp_stat[0]);

    // R6
    pm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PM_ACCESS) |-> $past(state == ST_DECODE));
endmodule

bind mbx_doorbell_ctrl mbx_checker #(.SRC_ID_W(SRC_ID_W), .SRC_ID(SRC_ID)) u_mbx_chk (
    .clk(clk), .rst_n(rst_n), .state(seq_state), .done(seq_done),
    .irq(irq_pulse), .irq_src(irq_src),
    .req_stat(ind_file[mbx_pkg::IX_REQ_STAT]),
    .rsp_stat(ind_file[mbx_pkg::IX_RSP_STAT])
);

// File: tb/test_mbx_doorbell_ctrl.sv
`timescale 1ns/1ps
module test_mbx_doorbell_ctrl;
    localparam logic [7:0] SRC = 8'h98;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq_pulse;
    logic [7:0]  irq_src;
    logic [47:0] irq_query_addr, irq_reply_addr;

    int n_chk = 0, n_err = 0, irq_cnt = 0;
    logic [7:0]  last_src;
    logic [47:0] last_q, last_r;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mbx_doorbell_ctrl #(.SRC_ID(SRC)) i_mbx_doorbell_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_pulse(irq_pulse),
        .irq_src(irq_src), .irq_query_addr(irq_query_addr), .irq_reply_addr(irq_reply_addr)
    );

    always @(negedge clk) if (rst_n && irq_pulse) begin
        irq_cnt++; last_src = irq_src; last_q = irq_query_addr; last_r = irq_reply_addr;
    end

    function automatic logic [31:0] exp_pm(input logic [31:0] a);
        if (a == 32'hC2100004) return 32'd3;
        if (a == 32'hC0500090 || a == 32'hC0500098 || a == 32'hC05000E0 || a == 32'hC05000E8)
            return 32'd1;
        return 32'd0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); host_addr = a; #1; d = host_rdata;
    endtask

    task automatic iwr(input logic [6:0] i, input logic [31:0] d);
        wr(5'd0, 32'(i)); wr(5'd1, d);
    endtask

    task automatic ird(input logic [6:0] i, output logic [31:0] d);
        wr(5'd0, 32'(i)); rd(5'd1, d);
    endtask

    task automatic ring(input logic [31:0] v);
        iwr(7'h31, v);
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d, cmd, a, s2, e2, e3;
        int ic;
        void'($urandom(32'd20211101));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < 10; k++) begin
            rd(5'(k), d); chk($sformatf("R1 word %0d", k), d, 0);
        end
        chk("R1 irq", irq_pulse, 0);
        ird(7'h4B, d); chk("R1 entry 4B", d, 0);

        // R2 main window
        wr(5'd0, 32'h25); rd(5'd0, d); chk("R2 index readback", d, 32'h25);
        for (int k = 0; k < 6; k++) begin
            logic [6:0] ix; logic [31:0] v;
            ix = 7'($urandom % 128);
            if (ix == 7'h31 || ix == 7'h37 || ix == 7'h32) ix = 7'h10;
            v = $urandom;
            iwr(ix, v); ird(ix, d); chk("R2 entry rw", d, v);
        end

        // R3 sub-bank independent of main file
        iwr(7'h05, 32'hAAAA0005);
        wr(5'd2, 32'd5); wr(5'd3, 32'h5555_0005);
        rd(5'd3, d); chk("R3 sub-bank", d, 32'h5555_0005);
        ird(7'h05, d); chk("R3 main untouched", d, 32'hAAAA0005);

        // R4 scratch
        for (int k = 0; k < 4; k++) begin
            wr(5'(4 + k), 32'h1000_0000 + k); rd(5'(4 + k), d);
            chk("R4 scratch rw", d, 32'h1000_0000 + k);
        end

        // R5 power-management stub
        wr(5'd8, 32'hC2100004); rd(5'd9, d); chk("R5 pm C2100004", d, 3);
        wr(5'd8, 32'hC05000E8); rd(5'd9, d); chk("R5 pm C05000E8", d, 1);
        wr(5'd8, 32'h12345678); wr(5'd9, 32'h55); rd(5'd9, d); chk("R5 pm write ignored", d, 0);

        // R6/R7/R8 randomized scratch commands
        for (int it = 0; it < 24; it++) begin
            case ($urandom % 4)
                0: cmd = 32'hA404;
                1: cmd = 32'hA505;
                2: cmd = 32'hA202;
                default: cmd = $urandom;
            endcase
            case ($urandom % 6)
                0: a = 32'hC2100004; 1: a = 32'hC0500090; 2: a = 32'hC0500098;
                3: a = 32'hC05000E0; 4: a = 32'hC05000E8; default: a = $urandom;
            endcase
            s2 = $urandom;
            wr(5'd4, cmd); wr(5'd5, a); wr(5'd6, s2); wr(5'd7, 32'h5A5A);
            iwr(7'h4A, 32'd1);
            ic = irq_cnt;
            ring(32'd1);
            e2 = (cmd == 32'hA404) ? exp_pm(a) : s2;
            e3 = (cmd == 32'hA404 || cmd == 32'hA505) ? 32'd0 : 32'hFFFFFFFF;
            rd(5'd6, d); chk($sformatf("R6 R7 R8 scratch2 cmd=%h", cmd), d, e2);
            rd(5'd7, d); chk($sformatf("R6 R7 R8 scratch3 cmd=%h", cmd), d, e3);
            ird(7'h4A, d); chk("R9 req status cleared", d, 0);
            chk("R13 no irq for scratch command", irq_cnt, ic);
        end
        wr(5'd8, 32'hC0500090); rd(5'd9, d); chk("R7 pm unchanged", d, 1);

        // R12 doorbell value other than 1
        iwr(7'h4A, 32'd7); iwr(7'h4B, 32'h10);
        ic = irq_cnt;
        ring(32'd2);
        ird(7'h4A, d); chk("R12 bad value 4A", d, 7);
        ird(7'h4B, d); chk("R12 bad value 4B", d, 32'h10);
        chk("R12 bad value no irq", irq_cnt, ic);

        // R9 handshake keeps other bits
        wr(5'd4, 32'hA505);
        ring(32'd1);
        ird(7'h4A, d); chk("R9 4A cleared", d, 0);
        ird(7'h4B, d); chk("R9 4B bit0 set", d, 32'h11);

        // R10 packet request
        iwr(7'h32, 32'h0003_1234); iwr(7'h33, 32'h89AB_CDEF);
        iwr(7'h35, 32'hFFFF_0001); iwr(7'h36, 32'h2222_3333);
        wr(5'd6, 32'h66); wr(5'd7, 32'h77);
        iwr(7'h4B, 32'd0);
        ic = irq_cnt;
        ring(32'd1);
        chk("R13 one irq pulse", irq_cnt, ic + 1);
        chk("R10 irq src", last_src, SRC);
        chk("R10 query addr", last_q, 48'h1234_89AB_CDEF);
        chk("R10 reply addr", last_r, 48'h0001_2222_3333);
        rd(5'd6, d); chk("R10 scratch2 kept", d, 32'h66);
        rd(5'd7, d); chk("R10 scratch3 kept", d, 32'h77);
        ird(7'h4B, d); chk("R9 packet 4B", d, 1);

        // R12 doorbell while busy
        ic = irq_cnt;
        iwr(7'h31, 32'd1);
        wr(5'd1, 32'd1);
        repeat (8) @(negedge clk);
        chk("R12 busy doorbell ignored", irq_cnt, ic + 1);
        iwr(7'h32, 32'd0);

        // R11 acknowledge and doorbell entries not stored
        iwr(7'h4A, 32'd9);
        iwr(7'h37, 32'h55);
        ird(7'h4A, d); chk("R11 ack clears 4A", d, 0);
        ird(7'h37, d); chk("R11 ack not stored", d, 0);
        ird(7'h31, d); chk("R11 doorbell not stored", d, 0);

        finish_run();
    end
endmodule